// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a read-only first-level cache. It is direct mapped and has 32 lines of four 32-bit words. A small fully associative victim buffer sits between the cache and the next memory level and keeps lines that were recently pushed out of the cache.

A request that hits the cache is answered without touching the victim buffer. A request that misses the cache is looked up in every victim entry at once, in the cycle after the miss. On a victim hit, the victim entry and the resident cache line swap places, and the requested word is returned as part of the swap. On a miss in both, the line is fetched from the next level and written into the cache. The line it displaces moves into the victim buffer, which gives up its least recently used entry when no slot is free.

Requesters keep `req_valid` high while `req_ready` is low. Exactly one `resp_valid` pulse answers each accepted request.

Top module: `victim_l1_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` and `mem_req_valid` are 0. The first access to any line is served from the next level, with `resp_src` = 2.
- R2: A cache hit raises `resp_valid` two rising edges after the accepting edge, with `resp_src` = 0 and no next-level request.
- R3: A cache miss that hits the victim buffer raises `resp_valid` three edges after the accepting edge, which is one cycle later than a hit, with `resp_src` = 1 and no next-level request.
- R4: A victim hit swaps the two lines. With two lines that share a cache index, every access after the first two alternates between them and returns `resp_src` = 1.
- R5: A miss in both pulses `mem_req_valid` for one cycle, three edges after the accepting edge, carrying the line address (request address without its two low bits). `resp_valid` follows on the edge after the one that samples `mem_rsp_valid`, with `resp_src` = 2.
- R6: On a fill, the valid line that was displaced from the cache enters the victim buffer. A later access to it returns `resp_src` = 1.
- R7: When all four victim entries are valid, the fill replaces the least recently used one. An access to that line then returns `resp_src` = 2.
- R8: The line placed into a slot by a swap or by a fill becomes the most recently used victim entry.
- R9: `req_ready` is low from the cycle after acceptance until the cycle in which `resp_valid` is high.
- R10: `resp_data` is the word selected by `req_addr[1:0]` from the addressed line, where word w of a line occupies bits [32w+31:32w].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 16 | Word address: tag [15:7], index [6:2], word [1:0] |
| req_ready | output | 1 | Block is idle and accepts a request |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_data | output | 32 | Requested word |
| resp_src | output | 2 | 0 cache hit, 1 victim hit, 2 next-level fill |
| mem_req_valid | output | 1 | One-cycle line fetch request |
| mem_req_line | output | 14 | Line address to fetch |
| mem_rsp_valid | input | 1 | Fetched line present |
| mem_rsp_line | input | 128 | Fetched line, word 0 in the low bits |

## Verification
Results are due at fixed distances from the accepting edge. A hit answers after two edges and a victim hit after three. A fill issues its fetch after three edges and answers one edge after the fetched line is sampled. The bench counts falling edges from acceptance, records the count at which the response and any fetch appear, and compares that count, the source code and the word against a reference model that tracks cache tags, victim entries and their age order. Directed conflict sequences at a single index exercise swap, insertion and least recently used eviction. Seeded random accesses over a small pool of conflicting lines cover the rest.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam logic [1:0] SRC_L1  = 2'd0;
  localparam logic [1:0] SRC_VB  = 2'd1;
  localparam logic [1:0] SRC_MEM = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_VCHK,
    ST_WAIT
  } vc_state_e;
endpackage

// File: rtl/vc_l1_array.sv
module vc_l1_array #(
  parameter int IDX_W  = 5,
  parameter int TAG_W  = 9,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W+LINE_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]        vld_q;

  // Tag and data storage: synchronous read, no reset, suitable for block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= {wr_tag, wr_line};
    if (rd_en) {rd_tag, rd_line} <= mem_q[rd_idx];
  end

  // Valid bits live in flops so that reset clears them.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (wr_en) vld_q[wr_idx] <= 1'b1;
      if (rd_en) rd_vld <= vld_q[rd_idx];
    end
  end
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
  parameter int N = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               touch_en,
  input  logic [$clog2(N)-1:0] touch_slot,
  output logic [$clog2(N)-1:0] lru_slot
);
  localparam int SW    = $clog2(N);
  localparam int AGE_W = (N > 1) ? $clog2(N) : 1;

  logic [AGE_W-1:0] age_q [N];
  logic [N-1:0]     oldest;

  // Ages always form a permutation of 0..N-1; 0 is most recent.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age_q[i] <= AGE_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (SW'(i) == touch_slot) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_slot]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_slot = '0;
    for (int i = 0; i < N; i++) begin
      oldest[i] = (age_q[i] == AGE_W'(N - 1));
      if (oldest[i]) lru_slot = SW'(i);
    end
  end

  p_one_oldest_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest) == 1);
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int N      = 4,
  parameter int LA_W   = 14,
  parameter int LINE_W = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LA_W-1:0]      look_addr,
  output logic                 hit,
  output logic [$clog2(N)-1:0] hit_slot,
  output logic [LINE_W-1:0]    hit_line,
  output logic [$clog2(N)-1:0] ins_slot,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_slot,
  input  logic                 wr_vld,
  input  logic [LA_W-1:0]      wr_addr,
  input  logic [LINE_W-1:0]    wr_line
);
  localparam int SW = $clog2(N);

  logic [N-1:0]      vld_q;
  logic [LA_W-1:0]   addr_q [N];
  logic [LINE_W-1:0] line_q [N];
  logic [N-1:0]      match;
  logic              any_free;
  logic [SW-1:0]     free_slot;
  logic [SW-1:0]     lru_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_slot] <= wr_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      addr_q[wr_slot] <= wr_addr;
      line_q[wr_slot] <= wr_line;
    end
  end

  // One comparator per entry, all evaluated together.
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (addr_q[g] == look_addr);
    end
  endgenerate

  always_comb begin
    hit       = |match;
    hit_slot  = '0;
    hit_line  = '0;
    any_free  = 1'b0;
    free_slot = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        hit_slot = SW'(i);
        hit_line = line_q[i];
      end
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        any_free  = 1'b1;
        free_slot = SW'(i);
      end
    end
    ins_slot = any_free ? free_slot : lru_slot;
  end

  // Every write makes its slot the most recent one.
  vc_lru #(.N(N)) u_lru (
    .clk       (clk),
    .rst       (rst),
    .touch_en  (wr_en),
    .touch_slot(wr_slot),
    .lru_slot  (lru_slot)
  );

  p_single_match_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
endmodule

// File: rtl/victim_l1_cache.sv
module victim_l1_cache
  import vc_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 16,
  parameter int WORDS    = 4,
  parameter int L1_LINES = 32,
  parameter int VB_N     = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  logic [AW-1:0]                  req_addr,
  output logic                           req_ready,
  output logic                           resp_valid,
  output logic [DW-1:0]                  resp_data,
  output logic [1:0]                     resp_src,
  output logic                           mem_req_valid,
  output logic [AW-$clog2(WORDS)-1:0]    mem_req_line,
  input  logic                           mem_rsp_valid,
  input  logic [DW*WORDS-1:0]            mem_rsp_line
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(L1_LINES);
  localparam int TAG_W  = AW - OFF_W - IDX_W;
  localparam int LA_W   = AW - OFF_W;
  localparam int LINE_W = DW * WORDS;
  localparam int SW     = $clog2(VB_N);

  vc_state_e         st_q;
  logic [AW-1:0]     addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic [OFF_W-1:0]  off_q;
  logic              req_fire;

  logic              l1_rd_vld;
  logic [TAG_W-1:0]  l1_rd_tag;
  logic [LINE_W-1:0] l1_rd_line;
  logic              l1_wr_en;
  logic [LINE_W-1:0] l1_wr_line;
  logic              l1_hit;

  logic              vb_hit;
  logic [SW-1:0]     vb_hit_slot;
  logic [LINE_W-1:0] vb_hit_line;
  logic [SW-1:0]     vb_ins_slot;
  logic              vb_wr_en;
  logic [SW-1:0]     vb_wr_slot;
  logic              vb_wr_vld;

  assign idx_q     = addr_q[OFF_W +: IDX_W];
  assign tag_q     = addr_q[AW-1 -: TAG_W];
  assign off_q     = addr_q[OFF_W-1:0];
  assign req_ready = (st_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign l1_hit    = l1_rd_vld && (l1_rd_tag == tag_q);

  function automatic logic [DW-1:0] pick(input logic [LINE_W-1:0] l,
                                         input logic [OFF_W-1:0] o);
    pick = '0;
    for (int i = 0; i < WORDS; i++)
      if (o == OFF_W'(i)) pick = l[i*DW +: DW];
  endfunction

  vc_l1_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_l1 (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (req_fire),
    .rd_idx (req_addr[OFF_W +: IDX_W]),
    .rd_vld (l1_rd_vld),
    .rd_tag (l1_rd_tag),
    .rd_line(l1_rd_line),
    .wr_en  (l1_wr_en),
    .wr_idx (idx_q),
    .wr_tag (tag_q),
    .wr_line(l1_wr_line)
  );

  vc_victim_buf #(.N(VB_N), .LA_W(LA_W), .LINE_W(LINE_W)) u_vb (
    .clk      (clk),
    .rst      (rst),
    .look_addr(addr_q[AW-1:OFF_W]),
    .hit      (vb_hit),
    .hit_slot (vb_hit_slot),
    .hit_line (vb_hit_line),
    .ins_slot (vb_ins_slot),
    .wr_en    (vb_wr_en),
    .wr_slot  (vb_wr_slot),
    .wr_vld   (vb_wr_vld),
    .wr_addr  ({l1_rd_tag, idx_q}),
    .wr_line  (l1_rd_line)
  );

  // Array updates: swap on a victim hit, refill plus insertion on a fetch.
  always_comb begin
    l1_wr_en   = 1'b0;
    l1_wr_line = mem_rsp_line;
    vb_wr_en   = 1'b0;
    vb_wr_slot = vb_ins_slot;
    vb_wr_vld  = 1'b1;
    if (st_q == ST_VCHK && vb_hit) begin
      l1_wr_en   = 1'b1;
      l1_wr_line = vb_hit_line;
      vb_wr_en   = 1'b1;
      vb_wr_slot = vb_hit_slot;
      vb_wr_vld  = l1_rd_vld;
    end else if (st_q == ST_WAIT && mem_rsp_valid) begin
      l1_wr_en = 1'b1;
      vb_wr_en = l1_rd_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      addr_q        <= '0;
      resp_valid    <= 1'b0;
      resp_data     <= '0;
      resp_src      <= SRC_L1;
      mem_req_valid <= 1'b0;
      mem_req_line  <= '0;
    end else begin
      resp_valid    <= 1'b0;
      mem_req_valid <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          st_q   <= ST_LOOK;
        end
        ST_LOOK: if (l1_hit) begin
          resp_valid <= 1'b1;
          resp_src   <= SRC_L1;
          resp_data  <= pick(l1_rd_line, off_q);
          st_q       <= ST_IDLE;
        end else begin
          st_q <= ST_VCHK;
        end
        ST_VCHK: if (vb_hit) begin
          resp_valid <= 1'b1;
          resp_src   <= SRC_VB;
          resp_data  <= pick(vb_hit_line, off_q);
          st_q       <= ST_IDLE;
        end else begin
          mem_req_valid <= 1'b1;
          mem_req_line  <= addr_q[AW-1:OFF_W];
          st_q          <= ST_WAIT;
        end
        default: if (mem_rsp_valid) begin
          resp_valid <= 1'b1;
          resp_src   <= SRC_MEM;
          resp_data  <= pick(mem_rsp_line, off_q);
          st_q       <= ST_IDLE;
        end
      endcase
    end
  end

  p_hit_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_src == SRC_L1) |-> $past(req_fire, 2));
  p_victim_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_src == SRC_VB) |-> $past(req_fire, 3));
  p_fetch_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  p_fill_follows_rsp_r5: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_src == SRC_MEM) |-> $past(mem_rsp_valid));
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    req_fire |=> !req_ready);
  p_ready_with_resp_r9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> req_ready);
endmodule

// File: tb/victim_l1_cache_bench.sv
module victim_l1_cache_bench;
  localparam int MEM_LAT = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [15:0]  req_addr = '0;
  logic         req_ready;
  logic         resp_valid;
  logic [31:0]  resp_data;
  logic [1:0]   resp_src;
  logic         mem_req_valid;
  logic [13:0]  mem_req_line;
  logic         mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_line = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  victim_l1_cache u_victim_l1_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_src(resp_src), .mem_req_valid(mem_req_valid),
    .mem_req_line(mem_req_line), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_line(mem_rsp_line)
  );

  // Reference model state
  logic [8:0]  m_tag [32];
  bit          m_v   [32];
  logic [13:0] m_vl  [4];
  bit          m_vv  [4];
  int          m_age [4];

  function automatic logic [31:0] mem_word(input logic [13:0] l, input int w);
    return {8'hC3, 2'b00, l, 6'b000000, 2'(w)};
  endfunction

  function automatic logic [127:0] mem_line(input logic [13:0] l);
    return {mem_word(l, 3), mem_word(l, 2), mem_word(l, 1), mem_word(l, 0)};
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic touch(input int s);
    int a;
    a = m_age[s];
    for (int i = 0; i < 4; i++) if (m_age[i] < a) m_age[i]++;
    m_age[s] = 0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_v[i] = 0;
    for (int i = 0; i < 4; i++) begin m_vv[i] = 0; m_age[i] = i; end
  endtask

  task automatic model_step(input logic [15:0] a, output int src);
    logic [4:0]  idx;
    logic [8:0]  tg;
    logic [13:0] ln;
    logic [13:0] old;
    int j, s;
    idx = a[6:2]; tg = a[15:7]; ln = a[15:2];
    old = {m_tag[idx], idx};
    if (m_v[idx] && m_tag[idx] == tg) begin
      src = 0;
    end else begin
      j = -1;
      for (int i = 0; i < 4; i++) if (m_vv[i] && m_vl[i] == ln) j = i;
      if (j >= 0) begin
        m_vv[j] = m_v[idx]; m_vl[j] = old; touch(j);
        src = 1;
      end else begin
        if (m_v[idx]) begin
          s = -1;
          for (int i = 3; i >= 0; i--) if (!m_vv[i]) s = i;
          if (s < 0) for (int i = 0; i < 4; i++) if (m_age[i] == 3) s = i;
          m_vv[s] = 1; m_vl[s] = old; touch(s);
        end
        src = 2;
      end
      m_tag[idx] = tg; m_v[idx] = 1;
    end
  endtask

  // One access: drives the request, plays the next level, checks everything.
  task automatic access(input logic [15:0] a, output int got_src);
    int exp_src, exp_lat, cnt, due, nreq;
    logic [13:0] seen_line;
    string rq;
    model_step(a, exp_src);
    rq = (exp_src == 0) ? "R2" : (exp_src == 1) ? "R3" : "R5";
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 1; due = -1; nreq = 0; seen_line = '0;
    while (!resp_valid && cnt < 40) begin
      if (mem_req_valid) begin
        nreq++; seen_line = mem_req_line; due = cnt + MEM_LAT;
      end
      if (cnt == due) begin
        mem_rsp_valid = 1'b1; mem_rsp_line = mem_line(seen_line);
      end
      @(negedge clk);
      cnt++;
      if (cnt == due + 1) mem_rsp_valid = 1'b0;
    end
    mem_rsp_valid = 1'b0;
    exp_lat = (exp_src == 0) ? 2 : (exp_src == 1) ? 3 : 3 + MEM_LAT + 1;
    got_src = resp_valid ? int'(resp_src) : -1;
    check(resp_valid && int'(resp_src) == exp_src, {rq, " source"}, got_src, exp_src);
    check(cnt == exp_lat, {rq, " latency"}, cnt, exp_lat);
    check(resp_data == mem_word(a[15:2], int'(a[1:0])), "R10 data",
          int'(resp_data), int'(mem_word(a[15:2], int'(a[1:0]))));
    check(nreq == (exp_src == 2 ? 1 : 0), {rq, " fetch count"}, nreq, exp_src == 2 ? 1 : 0);
    if (exp_src == 2)
      check(seen_line == a[15:2], "R5 fetch line", int'(seen_line), int'(a[15:2]));
    check(req_ready, "R9 ready with response", int'(req_ready), 1);
    @(negedge clk);
    check(!resp_valid, "R9 single response pulse", int'(resp_valid), 0);
  endtask

  function automatic logic [15:0] mk(input int tg, input int idx, input int off);
    return {9'(tg), 5'(idx), 2'(off)};
  endfunction

  initial begin
    int s, dummy;
    dummy = $urandom(32'h1F2E);
    model_reset();
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(resp_valid == 1'b0, "R1 no response after reset", int'(resp_valid), 0);
    check(mem_req_valid == 1'b0, "R1 no fetch after reset", int'(mem_req_valid), 0);

    // Ping-pong at one index (R1, R4)
    access(mk(1, 3, 0), s); check(s == 2, "R1 first access fills", s, 2);
    access(mk(2, 3, 1), s); check(s == 2, "R1 second line fills", s, 2);
    for (int k = 0; k < 6; k++) begin
      access(mk(1 + (k % 2), 3, k % 4), s);
      check(s == 1, "R4 ping-pong served by swap", s, 1);
    end
    access(mk(2, 3, 2), s); check(s == 0, "R2 repeated line hits", s, 0);

    // Fill displacement, LRU eviction and refresh (R6, R7, R8)
    for (int t = 10; t < 16; t++) begin
      access(mk(t, 7, t % 4), s); check(s == 2, "R6 conflict fill", s, 2);
    end
    access(mk(11, 7, 1), s); check(s == 1, "R6 displaced line kept", s, 1);
    access(mk(10, 7, 0), s); check(s == 2, "R7 oldest entry was evicted", s, 2);
    access(mk(13, 7, 3), s); check(s == 1, "R8 recent entry kept", s, 1);
    access(mk(12, 7, 2), s); check(s == 2, "R7 next oldest evicted", s, 2);
    access(mk(15, 7, 2), s); check(s == 1, "R8 swapped-out line retained", s, 1);

    // Seeded random accesses over a small conflicting pool
    for (int k = 0; k < 400; k++)
      access(mk(int'($urandom % 6), int'($urandom % 4), int'($urandom % 4)), s);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule